// File: doc/BRIEF.md
# Round-robin poll address selector

This block decides which device a serial peripheral bus host should poll next with a "talk register 0" command. It keeps a small history of what went out on the bus (the last command byte of any kind and the last talk-register-0 byte) together with a mask of device addresses that are enabled for polling. When the host controller asks for a poll, the block answers one cycle later with a command byte and a valid pulse. If it has nothing useful to add, the valid pulse stays low.

The policy stays on the same device for as long as that device remains enabled and quiet. It moves on when another device raised a service request while the current device was being polled, or when the current device has been removed from the mask. Moving on means taking the next enabled address above the current one, and wrapping to the lowest enabled address when no higher one exists. A chosen command that equals the last byte already on the bus is withheld, because the bus transceiver keeps repeating that byte by itself.

The host reports every transmitted command byte to the block. The mask is loaded with a strobe. Address 0 is reserved and can never be enabled.

Top module: `rr_poll_selector`

## Requirements
- R1: After reset, `poll_valid` and `poll_cmd` are zero, the enable mask is empty, the recorded last command is 0x00 and the recorded poll command is 0x0C (address 0).
- R2: Loading the mask always clears bit 0, so address 0 is never chosen. A loaded value of 0x0001 behaves as an empty mask.
- R3: While the mask is empty, a poll request produces no valid pulse.
- R4: The candidate is the upper nibble of the recorded poll command. It is chosen again when its mask bit is set and no move is forced.
- R5: When `srq_flag` is high at the request and the recorded last command equals the recorded poll command, the lowest enabled address above the candidate is chosen.
- R6: When `srq_flag` is high but the last command differs from the recorded poll command, the candidate is kept, provided it is enabled.
- R7: When the candidate's mask bit is clear, the lowest enabled address above it is chosen.
- R8: When a move is needed and no enabled address lies above the candidate, the lowest enabled address overall is chosen.
- R9: The poll command byte is the chosen address in bits [7:4] and 0xC (talk, register 0) in bits [3:0].
- R10: No valid pulse is given when the chosen command equals the recorded last command.
- R11: A `tx_valid` byte always replaces the recorded last command. It also replaces the recorded poll command only when its low nibble is 0xC. Other bytes leave the recorded poll command unchanged.
- R12: `poll_valid` is a single-cycle pulse, given only in the cycle after `poll_req` is sampled high. Selection uses the mask and history as they stood before that same clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mask_load | input | 1 | Strobe: load `mask_in` as the enable mask |
| mask_in | input | 16 | Enable mask, bit n enables address n |
| tx_valid | input | 1 | Strobe: a command byte was transmitted on the bus |
| tx_byte | input | 8 | The transmitted command byte |
| srq_flag | input | 1 | A service request was seen during the last poll |
| poll_req | input | 1 | Request a poll decision |
| poll_valid | output | 1 | One-cycle pulse: `poll_cmd` should be sent |
| poll_cmd | output | 8 | Selected poll command; holds its value between pulses |

## Verification
The hardest state to reach is the forced move under a service request. It needs the recorded last command and the recorded poll command to be the same byte, and it also needs a second device enabled above or below the current one. The port-level stimulus creates this state by reporting two transmitted bytes in a row, first a talk-register-0 byte and then the byte meant to become the last command. By choosing these two bytes to be equal or different, the stimulus separates the move from the keep case and the wrap from the step-up case. A non-poll byte is also reported between the two, which shows that the recorded poll command survives other traffic.

// File: rtl/rr_poll_pkg.sv
package rr_poll_pkg;

   // How the selector arrived at its address
   typedef enum logic [1:0] {
      PK_KEEP = 2'd0,
      PK_UP   = 2'd1,
      PK_WRAP = 2'd2,
      PK_NONE = 2'd3
   } pick_kind_e;

endpackage

// File: rtl/rr_poll_mask_reg.sv
module rr_poll_mask_reg #(
   parameter int NUM_DEV       = 16,
   parameter bit RESERVE_ADDR0 = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [NUM_DEV-1:0] din,
   output logic [NUM_DEV-1:0] mask_q
);

   logic [NUM_DEV-1:0] keep_bits;

   generate
      if (RESERVE_ADDR0) begin : g_rsv
         assign keep_bits = {{(NUM_DEV-1){1'b1}}, 1'b0};

         // R2: address 0 can never become enabled
         a_r2_addr0_clear: assert property (@(posedge clk) disable iff (!rst_n)
            load |=> !mask_q[0]);
      end else begin : g_all
         assign keep_bits = '1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         mask_q <= '0;
      else if (load)
         mask_q <= din & keep_bits;
   end

endmodule

// File: rtl/rr_poll_history.sv
module rr_poll_history #(
   parameter int ADDR_W     = 4,
   parameter int OPC_W      = 4,
   parameter int TALK0_CODE = 12
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    tx_valid,
   input  logic [ADDR_W+OPC_W-1:0] tx_byte,
   output logic [ADDR_W+OPC_W-1:0] last_cmd_q,
   output logic [ADDR_W+OPC_W-1:0] last_poll_q
);

   localparam int               CMD_W = ADDR_W + OPC_W;
   localparam logic [OPC_W-1:0] TALK0 = OPC_W'(TALK0_CODE);

   logic is_poll;
   assign is_poll = (tx_byte[OPC_W-1:0] == TALK0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         last_cmd_q  <= '0;
         last_poll_q <= {ADDR_W'(0), TALK0};
      end else if (tx_valid) begin
         last_cmd_q <= tx_byte;
         if (is_poll)
            last_poll_q <= tx_byte;
      end
   end

   // R11: a poll byte is recorded, any other byte leaves the record alone
   a_r11_poll_recorded: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid && (tx_byte[OPC_W-1:0] == TALK0) |=> last_poll_q == $past(tx_byte));

   a_r11_other_kept: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid && (tx_byte[OPC_W-1:0] != TALK0) |=> $stable(last_poll_q));

   a_r11_cmd_recorded: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |=> last_cmd_q == $past(tx_byte));

   logic [CMD_W-1:0] unused_w;
   assign unused_w = '0;

endmodule

// File: rtl/rr_poll_pick.sv
module rr_poll_pick
   import rr_poll_pkg::*;
#(
   parameter int ADDR_W     = 4,
   parameter int OPC_W      = 4,
   parameter int TALK0_CODE = 12
) (
   input  logic [(1<<ADDR_W)-1:0]   mask,
   input  logic [ADDR_W+OPC_W-1:0]  last_cmd,
   input  logic [ADDR_W+OPC_W-1:0]  last_poll,
   input  logic                     srq,
   output logic [ADDR_W-1:0]        pick_addr,
   output pick_kind_e               pick_kind,
   output logic [ADDR_W+OPC_W-1:0]  pick_cmd,
   output logic                     issue
);

   localparam int               NUM_DEV = 1 << ADDR_W;
   localparam int               CMD_W   = ADDR_W + OPC_W;
   localparam logic [OPC_W-1:0] TALK0   = OPC_W'(TALK0_CODE);

   function automatic logic [ADDR_W-1:0] f_lowest(input logic [NUM_DEV-1:0] v);
      logic [ADDR_W-1:0] r;
      r = '0;
      for (int i = NUM_DEV - 1; i >= 0; i--)
         if (v[i]) r = ADDR_W'(i);
      return r;
   endfunction

   logic [ADDR_W-1:0]  cand;
   logic               cand_on;
   logic               srq_move;
   logic [NUM_DEV-1:0] above_m;

   assign cand     = last_poll[CMD_W-1:OPC_W];
   assign cand_on  = mask[cand];
   assign srq_move = srq && (last_cmd == last_poll);

   generate
      for (genvar g = 0; g < NUM_DEV; g++) begin : g_above
         assign above_m[g] = mask[g] & (cand < ADDR_W'(g));
      end
   endgenerate

   always_comb begin
      if (mask == '0) begin
         pick_kind = PK_NONE;
         pick_addr = cand;
      end else if (cand_on && !srq_move) begin
         pick_kind = PK_KEEP;
         pick_addr = cand;
      end else if (|above_m) begin
         pick_kind = PK_UP;
         pick_addr = f_lowest(above_m);
      end else begin
         pick_kind = PK_WRAP;
         pick_addr = f_lowest(mask);
      end
   end

   assign pick_cmd = {pick_addr, TALK0};
   assign issue    = (pick_kind != PK_NONE) && (pick_cmd != last_cmd);

   always_comb begin
      if (pick_kind != PK_NONE) begin
         a_r7_pick_enabled: assert (mask[pick_addr]);
      end
      if (pick_kind == PK_UP) begin
         a_r5_moves_up: assert (pick_addr > cand);
      end
      if (pick_kind == PK_WRAP) begin
         a_r8_wraps_low: assert (pick_addr <= cand);
      end
   end

endmodule

// File: rtl/rr_poll_selector.sv
module rr_poll_selector
   import rr_poll_pkg::*;
#(
   parameter int ADDR_W        = 4,
   parameter int OPC_W         = 4,
   parameter int TALK0_CODE    = 12,
   parameter bit RESERVE_ADDR0 = 1'b1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          mask_load,
   input  logic [(1<<ADDR_W)-1:0]        mask_in,
   input  logic                          tx_valid,
   input  logic [ADDR_W+OPC_W-1:0]       tx_byte,
   input  logic                          srq_flag,
   input  logic                          poll_req,
   output logic                          poll_valid,
   output logic [ADDR_W+OPC_W-1:0]       poll_cmd
);

   localparam int               NUM_DEV = 1 << ADDR_W;
   localparam int               CMD_W   = ADDR_W + OPC_W;
   localparam logic [OPC_W-1:0] TALK0   = OPC_W'(TALK0_CODE);

   generate
      if (ADDR_W < 1 || ADDR_W > 8) begin : g_bad_addr_w
         $error("rr_poll_selector: ADDR_W must lie in 1..8");
      end
      if (TALK0_CODE < 0 || TALK0_CODE >= (1 << OPC_W)) begin : g_bad_code
         $error("rr_poll_selector: TALK0_CODE does not fit in OPC_W bits");
      end
   endgenerate

   logic [NUM_DEV-1:0] mask_q;
   logic [CMD_W-1:0]   last_cmd_q;
   logic [CMD_W-1:0]   last_poll_q;
   logic [ADDR_W-1:0]  pick_addr;
   pick_kind_e         pick_kind;
   logic [CMD_W-1:0]   pick_cmd;
   logic               issue;

   rr_poll_mask_reg #(
      .NUM_DEV       (NUM_DEV),
      .RESERVE_ADDR0 (RESERVE_ADDR0)
   ) mask_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (mask_load),
      .din    (mask_in),
      .mask_q (mask_q)
   );

   rr_poll_history #(
      .ADDR_W     (ADDR_W),
      .OPC_W      (OPC_W),
      .TALK0_CODE (TALK0_CODE)
   ) hist_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .tx_valid    (tx_valid),
      .tx_byte     (tx_byte),
      .last_cmd_q  (last_cmd_q),
      .last_poll_q (last_poll_q)
   );

   rr_poll_pick #(
      .ADDR_W     (ADDR_W),
      .OPC_W      (OPC_W),
      .TALK0_CODE (TALK0_CODE)
   ) pick_i (
      .mask      (mask_q),
      .last_cmd  (last_cmd_q),
      .last_poll (last_poll_q),
      .srq       (srq_flag),
      .pick_addr (pick_addr),
      .pick_kind (pick_kind),
      .pick_cmd  (pick_cmd),
      .issue     (issue)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         poll_valid <= 1'b0;
         poll_cmd   <= '0;
      end else begin
         poll_valid <= poll_req && issue;
         if (poll_req && issue)
            poll_cmd <= pick_cmd;
      end
   end

   // R12: a pulse only ever follows a request
   a_r12_valid_from_req: assert property (@(posedge clk) disable iff (!rst_n)
      poll_valid |-> $past(poll_req));

   // R12: never two pulses back to back without two requests
   a_r12_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      poll_valid && !poll_req |=> !poll_valid);

   // R9: command format
   a_r9_talk0_code: assert property (@(posedge clk) disable iff (!rst_n)
      poll_valid |-> poll_cmd[OPC_W-1:0] == TALK0);

   // R10: never repeat the byte already on the bus
   a_r10_no_repeat: assert property (@(posedge clk) disable iff (!rst_n)
      poll_valid |-> poll_cmd != $past(last_cmd_q));

   // R3: empty mask stays silent
   a_r3_empty_silent: assert property (@(posedge clk) disable iff (!rst_n)
      $past(poll_req) && ($past(mask_q) == '0) |-> !poll_valid);

   // R2: reserved address never leaves the block
   generate
      if (RESERVE_ADDR0) begin : g_chk_rsv
         a_r2_no_addr0: assert property (@(posedge clk) disable iff (!rst_n)
            poll_valid |-> poll_cmd[CMD_W-1:OPC_W] != '0);
      end
   endgenerate

endmodule

// File: tb/rr_poll_selector_tb_top.sv
`timescale 1ns/1ps
module rr_poll_selector_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mask_load = 1'b0;
   logic [15:0] mask_in = '0;
   logic        tx_valid = 1'b0;
   logic [7:0]  tx_byte = '0;
   logic        srq_flag = 1'b0;
   logic        poll_req = 1'b0;
   logic        poll_valid;
   logic [7:0]  poll_cmd;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   rr_poll_selector dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .mask_load  (mask_load),
      .mask_in    (mask_in),
      .tx_valid   (tx_valid),
      .tx_byte    (tx_byte),
      .srq_flag   (srq_flag),
      .poll_req   (poll_req),
      .poll_valid (poll_valid),
      .poll_cmd   (poll_cmd)
   );

   typedef struct packed {
      logic [15:0] mask;
      logic [7:0]  tx0;   // sent first (poll byte when low nibble is C)
      logic [7:0]  tx1;   // sent second, becomes last command
      logic        srq;
      logic        ev;
      logic [7:0]  ecmd;
      logic [3:0]  rq;    // requirement number for the message
   } vec_t;

   localparam int NV = 14;
   localparam vec_t TBL [NV] = '{
      '{16'h0004, 8'h2C, 8'h20, 1'b0, 1'b1, 8'h2C, 4'd4},  // R4 keep
      '{16'h0004, 8'h2C, 8'h2C, 1'b0, 1'b0, 8'h00, 4'd10}, // R10 repeat withheld
      '{16'h0014, 8'h2C, 8'h2C, 1'b1, 1'b1, 8'h4C, 4'd5},  // R5 srq move up
      '{16'h0014, 8'h2C, 8'h3B, 1'b1, 1'b1, 8'h2C, 4'd6},  // R6 srq, other cmd
      '{16'h0030, 8'h2C, 8'h2C, 1'b0, 1'b1, 8'h4C, 4'd7},  // R7 candidate off
      '{16'h0006, 8'h9C, 8'h9C, 1'b0, 1'b1, 8'h1C, 4'd8},  // R8 wrap
      '{16'h8002, 8'hFC, 8'hFC, 1'b1, 1'b1, 8'h1C, 4'd8},  // R8 srq at top wraps
      '{16'h0000, 8'h2C, 8'h20, 1'b0, 1'b0, 8'h00, 4'd3},  // R3 empty
      '{16'h0001, 8'h2C, 8'h20, 1'b0, 1'b0, 8'h00, 4'd2},  // R2 bit0 only
      '{16'h0003, 8'h5C, 8'h5C, 1'b0, 1'b1, 8'h1C, 4'd2},  // R2 wrap skips 0
      '{16'h0408, 8'hAC, 8'h3D, 1'b0, 1'b1, 8'hAC, 4'd11}, // R11 non-poll kept
      '{16'h0408, 8'hAC, 8'h3C, 1'b0, 1'b0, 8'h00, 4'd11}, // R11 poll recorded
      '{16'h8000, 8'h7C, 8'h7C, 1'b0, 1'b1, 8'hFC, 4'd9},  // R9 address 15
      '{16'h0A0A, 8'h3C, 8'h3C, 1'b1, 1'b1, 8'h9C, 4'd5}   // R5 skip disabled
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic load_mask(input logic [15:0] m);
      @(negedge clk); mask_load = 1'b1; mask_in = m;
      @(negedge clk); mask_load = 1'b0;
   endtask

   task automatic send(input logic [7:0] b);
      @(negedge clk); tx_valid = 1'b1; tx_byte = b;
      @(negedge clk); tx_valid = 1'b0;
   endtask

   // raise poll_req for one edge; on return outputs reflect that edge
   task automatic ask(input logic s);
      @(negedge clk); poll_req = 1'b1; srq_flag = s;
      @(negedge clk); poll_req = 1'b0; srq_flag = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state of outputs
      chk("R1 valid", 32'(poll_valid), 32'd0);
      chk("R1 cmd", 32'(poll_cmd), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 recorded poll at address 0: candidate off, next up is 1
      load_mask(16'h0012);
      ask(1'b0);
      chk("R1 first pick valid", 32'(poll_valid), 32'd1);
      chk("R1 first pick cmd", 32'(poll_cmd), 32'h1C);
      // R12 single-cycle pulse
      @(negedge clk);
      chk("R12 pulse ends", 32'(poll_valid), 32'd0);
      chk("R12 cmd held", 32'(poll_cmd), 32'h1C);

      for (int i = 0; i < NV; i++) begin
         load_mask(TBL[i].mask);
         send(TBL[i].tx0);
         send(TBL[i].tx1);
         ask(TBL[i].srq);
         chk($sformatf("R%0d vec %0d valid", TBL[i].rq, i), 32'(poll_valid), 32'(TBL[i].ev));
         if (TBL[i].ev)
            chk($sformatf("R%0d vec %0d cmd", TBL[i].rq, i), 32'(poll_cmd), 32'(TBL[i].ecmd));
      end

      // R12 no request: mask and history changes give no pulse
      load_mask(16'h00F0);
      send(8'h1C);
      repeat (4) @(negedge clk);
      chk("R12 no req no pulse", 32'(poll_valid), 32'd0);

      // R12 selection uses state before the edge: request and mask load together
      @(negedge clk);
      poll_req = 1'b1; mask_load = 1'b1; mask_in = 16'h0002;
      @(negedge clk);
      poll_req = 1'b0; mask_load = 1'b0;
      chk("R12 old mask used", 32'(poll_cmd), 32'h4C);
      chk("R12 old mask valid", 32'(poll_valid), 32'd1);

      // R1 reset mid-run clears outputs and mask
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk);
      chk("R1 reset valid", 32'(poll_valid), 32'd0);
      chk("R1 reset cmd", 32'(poll_cmd), 32'd0);
      rst_n = 1'b1;
      ask(1'b0);
      chk("R1 mask empty after reset", 32'(poll_valid), 32'd0);

      done = 1'b1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule